// File: doc/BRIEF.md
# Auto-Detecting Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel sample words. It runs directly on the bit clock and samples the word-select and serial-data lines on each rising edge. It does not need to be told whether the sender uses 16 or 32 bit clocks per channel slot. It measures the spacing between word-select transitions, checks it against the two legal slot widths, and reports the width it has locked onto.

Two static configuration inputs adapt it to the sender. One sets which word-select level carries the left channel. The other chooses whether the first data bit of a slot comes on the same clock as the word-select transition or one clock later. Each completed left/right pair appears on two 32-bit outputs with a single-clock strobe. A slot of any other length raises a one-clock format-error pulse, and its data is dropped.

Top module: `i2s_autofmt_rx`

## Requirements
- R1: Word select and serial data are sampled on the rising edge of `clk_i`. Each channel word is received most significant bit first.
- R2: When a slot is 16 clocks long, its 16 received bits fill `left_o`/`right_o` bits 31:16, and bits 15:0 read zero.
- R3: When a slot is 32 clocks long, all 32 received bits fill the output word, with the first bit received at bit 31.
- R4: With `msb_dly_i` = 0, the first bit of a slot is the one sampled on the clock where word select changes. With `msb_dly_i` = 1, it is the one sampled on the next clock.
- R5: With `ws_pol_i` = 0, the slot taken while word select is low is the left channel and opens the frame. With `ws_pol_i` = 1, the slot taken while word select is high is the left channel.
- R6: `mode32_o` reads 1 when the words of the latest pair came from 32-clock slots and 0 when they came from 16-clock slots. No input selects the mode.
- R7: A slot whose length is neither 16 nor 32 clocks raises `fmt_err_o` for exactly one clock. Its data is discarded, and any left word still waiting for its right partner is dropped too.
- R8: A slot is accepted only if the slot before it had the same legal length. So after reset, after an error, or after a change of width, the first frame produces no pair.
- R9: `valid_o` is high for exactly one clock once a frame's left word and then its right word have both been accepted. `left_o` and `right_o` change only on that clock.
- R10: While `rst_ni` is low, `left_o` and `right_o` read zero, and `valid_o`, `fmt_err_o` and `mode32_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ws_i | input | 1 | Word-select line |
| sd_i | input | 1 | Serial data line |
| ws_pol_i | input | 1 | 1: left channel while word select is high |
| msb_dly_i | input | 1 | 1: first data bit one clock after the word-select change |
| left_o | output | 32 | Left sample word, left-aligned |
| right_o | output | 32 | Right sample word, left-aligned |
| valid_o | output | 1 | One-clock strobe for a new pair |
| mode32_o | output | 1 | Detected slot width: 1 = 32 clocks, 0 = 16 clocks |
| fmt_err_o | output | 1 | One-clock pulse for an illegal slot length |

## Verification
The streams are built from random sample data under every combination of polarity and delay setting. Runs with only 16-clock slots and runs with only 32-clock slots show whether word placement and zero fill depend on the measured width. Streams that change width between frames, including one that alternates on every frame, show whether a frame is held back until two slots in a row agree. Bursts separated by idle stretches of 7 and 5 clocks give illegal slot lengths, which check the error pulse and the dropping of a left word that has no right partner.

// File: rtl/i2s_rx_pkg.sv
`timescale 1ns/1ps
package i2s_rx_pkg;
  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_SHORT = 2'd1,
    CLS_LONG  = 2'd2
  } slot_cls_e;
endpackage

// File: rtl/i2s_align.sv
`timescale 1ns/1ps
// Re-times word select so the MSB coincides with the aligned transition.
module i2s_align (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ws_i,
  input  logic sd_i,
  input  logic dly_en_i,
  output logic sd_a_o,
  output logic edge_o,
  output logic prev_lvl_o
);
  logic       ws_d1_q;
  logic       ws_a;
  logic       ws_a_q;
  logic [1:0] prime_q;

  assign ws_a = dly_en_i ? ws_d1_q : ws_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_d1_q <= 1'b0;
      ws_a_q  <= 1'b0;
      prime_q <= 2'd0;
    end else begin
      ws_d1_q <= ws_i;
      ws_a_q  <= ws_a;
      if (prime_q != 2'd2) prime_q <= prime_q + 2'd1;
    end
  end

  // compare only once both history stages hold sampled values
  assign edge_o     = (prime_q == 2'd2) && (ws_a != ws_a_q);
  assign prev_lvl_o = ws_a_q;
  assign sd_a_o     = sd_i;
endmodule

// File: rtl/i2s_slot_meter.sv
`timescale 1ns/1ps
module i2s_slot_meter
  import i2s_rx_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned SHORT_N = 16,
  parameter int unsigned LONG_N  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              edge_i,
  input  logic              sd_i,
  output logic              done_o,
  output slot_cls_e         cls_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W   = $clog2(LONG_N) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int unsigned PAD_W   = WORD_W - SHORT_N;

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic              started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      started_q <= 1'b0;
    end else if (edge_i) begin
      cnt_q     <= CNT_W'(1);
      sh_q      <= {{(WORD_W-1){1'b0}}, sd_i};
      started_q <= 1'b1;
    end else begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
      sh_q <= {sh_q[WORD_W-2:0], sd_i};
    end
  end

  // first edge after reset only opens a slot
  assign done_o = edge_i && started_q;

  always_comb begin
    if (cnt_q == CNT_W'(SHORT_N))     cls_o = CLS_SHORT;
    else if (cnt_q == CNT_W'(LONG_N)) cls_o = CLS_LONG;
    else                              cls_o = CLS_NONE;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign word_o = (cls_o == CLS_SHORT) ? {sh_q[SHORT_N-1:0], {PAD_W{1'b0}}} : sh_q;
    end else begin : g_nopad
      assign word_o = sh_q;
    end
  endgenerate
endmodule

// File: rtl/i2s_pair_asm.sv
`timescale 1ns/1ps
module i2s_pair_asm
  import i2s_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  slot_cls_e         cls_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              lvl_i,
  input  logic              pol_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic              mode32_o,
  output logic              fmt_err_o
);
  slot_cls_e         prev_cls_q;
  logic [WORD_W-1:0] lbuf_q;
  logic              lflag_q;
  logic              accept;
  logic              is_left;

  assign is_left = (lvl_i == pol_i);
  assign accept  = done_i && (cls_i != CLS_NONE) && (cls_i == prev_cls_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_cls_q <= CLS_NONE;
      lbuf_q     <= '0;
      lflag_q    <= 1'b0;
      left_o     <= '0;
      right_o    <= '0;
      valid_o    <= 1'b0;
      mode32_o   <= 1'b0;
      fmt_err_o  <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      fmt_err_o <= done_i && (cls_i == CLS_NONE);
      if (done_i) prev_cls_q <= cls_i;
      if (accept) begin
        mode32_o <= (cls_i == CLS_LONG);
        if (is_left) begin
          lbuf_q  <= word_i;
          lflag_q <= 1'b1;
        end else if (lflag_q) begin
          left_o  <= lbuf_q;
          right_o <= word_i;
          valid_o <= 1'b1;
          lflag_q <= 1'b0;
        end
      end else if (done_i) begin
        lflag_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2s_autofmt_rx.sv
`timescale 1ns/1ps
module i2s_autofmt_rx
  import i2s_rx_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned SHORT_N = 16,
  parameter int unsigned LONG_N  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ws_i,
  input  logic              sd_i,
  input  logic              ws_pol_i,
  input  logic              msb_dly_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic              mode32_o,
  output logic              fmt_err_o
);
  logic              sd_a;
  logic              ws_edge;
  logic              prev_lvl;
  logic              slot_done;
  slot_cls_e         slot_cls;
  logic [WORD_W-1:0] slot_word;

  i2s_align u_align (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ws_i       (ws_i),
    .sd_i       (sd_i),
    .dly_en_i   (msb_dly_i),
    .sd_a_o     (sd_a),
    .edge_o     (ws_edge),
    .prev_lvl_o (prev_lvl)
  );

  i2s_slot_meter #(
    .WORD_W  (WORD_W),
    .SHORT_N (SHORT_N),
    .LONG_N  (LONG_N)
  ) u_meter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (ws_edge),
    .sd_i   (sd_a),
    .done_o (slot_done),
    .cls_o  (slot_cls),
    .word_o (slot_word)
  );

  i2s_pair_asm #(
    .WORD_W (WORD_W)
  ) u_pair (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (slot_done),
    .cls_i     (slot_cls),
    .word_i    (slot_word),
    .lvl_i     (prev_lvl),
    .pol_i     (ws_pol_i),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o),
    .mode32_o  (mode32_o),
    .fmt_err_o (fmt_err_o)
  );
endmodule

// File: rtl/i2s_autofmt_rx_chk.sv
`timescale 1ns/1ps
module i2s_autofmt_rx_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] left_o,
  input logic [WORD_W-1:0] right_o,
  input logic              valid_o,
  input logic              mode32_o,
  input logic              fmt_err_o
);
  // R9
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R9
  left_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_o != $past(left_o)) |-> valid_o);
  // R9
  right_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (right_o != $past(right_o)) |-> valid_o);
  // R7
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |=> !fmt_err_o);
  // R7
  err_no_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fmt_err_o && valid_o));
  // R2
  short_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !mode32_o) |-> (left_o[WORD_W/2-1:0] == '0 && right_o[WORD_W/2-1:0] == '0));
endmodule

bind i2s_autofmt_rx i2s_autofmt_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .left_o    (left_o),
  .right_o   (right_o),
  .valid_o   (valid_o),
  .mode32_o  (mode32_o),
  .fmt_err_o (fmt_err_o)
);

// File: tb/i2s_autofmt_rx_tb.sv
`timescale 1ns/1ps
module i2s_autofmt_rx_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ws_i = 1'b0;
  logic        sd_i = 1'b0;
  logic        ws_pol_i = 1'b0;
  logic        msb_dly_i = 1'b0;
  logic [31:0] left_o, right_o;
  logic        valid_o, mode32_o, fmt_err_o;

  always #2 clk_i = ~clk_i;

  i2s_autofmt_rx u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ws_i      (ws_i),
    .sd_i      (sd_i),
    .ws_pol_i  (ws_pol_i),
    .msb_dly_i (msb_dly_i),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o),
    .mode32_o  (mode32_o),
    .fmt_err_o (fmt_err_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // aligned stream: sd_arr[k] is the bit that belongs to aligned ws_arr[k]
  logic ws_arr [0:8191];
  logic sd_arr [0:8191];
  int   n_bits;

  logic [31:0] exp_l [$];
  logic [31:0] exp_r [$];
  bit          exp_m [$];
  int          exp_err;
  int          got_err;
  int          stab_viol;
  bit          prev_valid;
  logic [31:0] prev_l, prev_r;

  function automatic logic [31:0] fit(bit m32, logic [31:0] d);
    return m32 ? d : {d[15:0], 16'h0000};
  endfunction

  task automatic put(logic w, logic d);
    ws_arr[n_bits] = w;
    sd_arr[n_bits] = d;
    n_bits++;
  endtask

  // R1: MSB first within each slot
  task automatic put_slot(logic lvl, bit m32, logic [31:0] d);
    int len = m32 ? 32 : 16;
    for (int j = len - 1; j >= 0; j--) put(lvl, d[j]);
  endtask

  task automatic put_idle(logic lvl, int len);
    for (int j = 0; j < len; j++) put(lvl, 1'($urandom));
  endtask

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor, sampled 1ns after the active edge
  always @(posedge clk_i) begin
    #1;
    if (rst_ni) begin
      if (fmt_err_o) got_err++;
      if (valid_o && prev_valid) stab_viol++;
      if (!valid_o && (left_o != prev_l || right_o != prev_r)) stab_viol++;
      if (valid_o) begin
        if (exp_l.size() == 0) begin
          chk(0, "R8", "unexpected pair", left_o, 32'h0);
        end else begin
          logic [31:0] el, er;
          bit em;
          el = exp_l.pop_front();
          er = exp_r.pop_front();
          em = exp_m.pop_front();
          // R5 channel order, R4 alignment, R2/R3 placement
          chk(left_o == el, em ? "R3" : "R2", "left word", left_o, el);
          chk(right_o == er, em ? "R3" : "R2", "right word", right_o, er);
          chk(mode32_o == em, "R6", "mode flag", 32'(mode32_o), 32'(em));
        end
      end
    end
    prev_valid = valid_o;
    prev_l = left_o;
    prev_r = right_o;
  end

  // R10 reset state
  task automatic do_reset(bit pol, bit dly);
    @(negedge clk_i);
    rst_ni = 1'b0;
    ws_pol_i = pol;
    msb_dly_i = dly;
    repeat (3) @(negedge clk_i);
    chk(left_o == 0 && right_o == 0, "R10", "words in reset", left_o | right_o, 32'h0);
    chk(!valid_o && !fmt_err_o && !mode32_o, "R10", "flags in reset",
        {29'h0, valid_o, fmt_err_o, mode32_o}, 32'h0);
  endtask

  // mode_sel: 0 = all 16, 1 = all 32, 2 = alternate, 3 = random
  task automatic run_test(bit pol, bit dly, int nburst, int nframe, int mode_sel);
    bit m, pm;
    logic [31:0] dl, dr;
    exp_l.delete(); exp_r.delete(); exp_m.delete();
    exp_err = 0;
    got_err = 0;
    stab_viol = 0;
    n_bits = 0;
    do_reset(pol, dly);
    put_idle(~pol, 5);
    for (int b = 0; b < nburst; b++) begin
      if (b > 0) begin
        put_idle(pol, 7);   // R7 illegal length
        put_idle(~pol, 5);  // R7 illegal length
        exp_err += 2;
      end
      pm = 0;
      for (int f = 0; f < nframe; f++) begin
        case (mode_sel)
          0: m = 0;
          1: m = 1;
          2: m = f[0];
          default: m = (f == 0) ? 1'($urandom) : (($urandom % 4 == 0) ? ~pm : pm);
        endcase
        dl = $urandom;
        dr = $urandom;
        put_slot(pol, m, dl);
        put_slot(~pol, m, dr);
        // R8: pair only if previous frame had same width
        if (f > 0 && m == pm) begin
          exp_l.push_back(fit(m, dl));
          exp_r.push_back(fit(m, dr));
          exp_m.push_back(m);
        end
        pm = m;
      end
    end
    put_idle(pol, 7);
    ws_arr[n_bits] = ws_arr[n_bits-1];
    for (int k = 0; k < n_bits; k++) begin
      if (k == 0) rst_ni = 1'b1;
      sd_i = sd_arr[k];
      ws_i = dly ? ws_arr[k+1] : ws_arr[k];  // R4 transition one clock before MSB
      @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
    chk(exp_l.size() == 0, "R8", "pairs missing", 32'(exp_l.size()), 32'h0);
    chk(got_err == exp_err, "R7", "error pulses", 32'(got_err), 32'(exp_err));
    chk(stab_viol == 0, "R9", "strobe width / hold", 32'(stab_viol), 32'h0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    run_test(0, 1, 2, 6, 0);  // R2 16-clock slots, delayed MSB
    run_test(1, 0, 2, 6, 1);  // R3 32-clock slots, swapped polarity (R5)
    run_test(0, 0, 1, 8, 2);  // R8 alternating width, no pairs
    run_test(1, 1, 3, 5, 0);
    for (int t = 0; t < 8; t++)
      run_test(1'($urandom), 1'($urandom), 1 + ($urandom % 3), 4 + ($urandom % 6), 3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule